// File: doc/BRIEF.md
# Carry-Zero Arithmetic Logic Unit

This block is the 8-bit datapath arithmetic unit of a small accumulator-based CPU core. It is purely combinational. The core puts two operands, a 3-bit function code and its current carry (C) and zero (Z) flags on the inputs. In the same cycle the block returns the result byte, a strobe that says whether the core should write the result back, and the next values of both flags.

Seven functions are available: add, subtract, compare, NOR, pass-through (used for loads), increment and decrement. A spare eighth code leaves everything as it was. Each function updates its own fixed subset of the flags, and any flag it does not own is passed through unchanged. Subtraction and compare are built on the same adder as addition, so C after a subtraction is the carry-out of `A + ~B + 1`. C=1 therefore means that no borrow occurred (A ≥ B unsigned).

Increment and decrement act on the A operand, so the core routes its index register onto A for those codes. Both wrap modulo 256.

Top module: `alu_cz`

## Requirements
- R1: Code 0 (add): `res_o = (a_i + b_i) mod 256`, `c_o` = carry out of bit 7, `wr_en_o = 1`.
- R2: Code 1 (subtract): `res_o = (a_i - b_i) mod 256`, `c_o = 1` exactly when `a_i >= b_i` unsigned, `wr_en_o = 1`.
- R3: Code 2 (compare): `c_o` and `z_o` equal those of code 1 for the same operands, `res_o` shows the difference, and `wr_en_o = 0`.
- R4: Code 3 (NOR): `res_o = ~(a_i | b_i)`, `wr_en_o = 1`, `c_o = c_i`.
- R5: Code 4 (pass): `res_o = b_i`, `wr_en_o = 1`, `c_o = c_i`.
- R6: Code 5 (increment) gives `res_o = (a_i + 1) mod 256` and code 6 (decrement) gives `res_o = (a_i - 1) mod 256`. Both have `wr_en_o = 1` and `c_o = c_i`.
- R7: For codes 0 to 6, `z_o = 1` exactly when `res_o` is zero.
- R8: Code 7 (hold): `c_o = c_i`, `z_o = z_i`, `wr_en_o = 0`, `res_o = a_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand (accumulator or index register) |
| b_i | input | 8 | Second operand (memory or immediate byte) |
| op_i | input | 3 | Function code, 0 to 7 as in R1 to R8 |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| c_o | output | 1 | Next carry flag |
| z_o | output | 1 | Next zero flag |

## Verification
The bench targets the carry boundary of the adder.
- 0xFF + 0x01 must give zero with C set. A design that dropped the ninth bit would clear C.
- Equal operands on subtract must give C=1 and Z=1. A design that reported borrow polarity would show C=0.
- Subtracting 1 from 0 must give 0xFF with C=0.

Increment of 0xFF and decrement of 0x00 probe the wrap and check that C survives unchanged. A design that let the adder's carry leak into the flag would corrupt it. Compare and hold are checked for a low write strobe, and every flag-preserving code is driven with both values of the incoming C and Z.

// File: rtl/alu_cz_pkg.sv
package alu_cz_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_NOR  = 3'd3,
        OP_PASS = 3'd4,
        OP_INC  = 3'd5,
        OP_DEC  = 3'd6,
        OP_HOLD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_SUM  = 2'd0,
        SEL_NOR  = 2'd1,
        SEL_PASS = 2'd2,
        SEL_A    = 2'd3
    } res_sel_e;

    // Control word produced by the decoder for one function code
    typedef struct packed {
        logic     wr;      // result write-back
        logic     upd_c;   // function owns carry
        logic     upd_z;   // function owns zero
        logic     zero_b;  // replace B by zero before the adder
        logic     inv_b;   // invert B before the adder
        logic     cin;     // adder carry in
        res_sel_e sel;     // result source
    } alu_ctl_t;

endpackage

// File: rtl/alu_cz_decode.sv
module alu_cz_decode
    import alu_cz_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output alu_ctl_t        ctl_o
);

    alu_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{wr: 1'b1, upd_c: 1'b0, upd_z: 1'b1, zero_b: 1'b0,
                  inv_b: 1'b0, cin: 1'b0, sel: SEL_SUM};
        unique case (alu_op_e'(op_i))
            OP_ADD:  ctl_d.upd_c = 1'b1;
            OP_SUB: begin
                ctl_d.upd_c = 1'b1;
                ctl_d.inv_b = 1'b1;
                ctl_d.cin   = 1'b1;
            end
            OP_CMP: begin
                ctl_d.upd_c = 1'b1;
                ctl_d.inv_b = 1'b1;
                ctl_d.cin   = 1'b1;
                ctl_d.wr    = 1'b0;
            end
            OP_NOR:  ctl_d.sel = SEL_NOR;
            OP_PASS: ctl_d.sel = SEL_PASS;
            OP_INC: begin
                ctl_d.zero_b = 1'b1;
                ctl_d.cin    = 1'b1;
            end
            OP_DEC: begin
                // A + all-ones = A - 1
                ctl_d.zero_b = 1'b1;
                ctl_d.inv_b  = 1'b1;
            end
            OP_HOLD: begin
                ctl_d.wr    = 1'b0;
                ctl_d.upd_z = 1'b0;
                ctl_d.sel   = SEL_A;
            end
            default: ctl_d.wr = 1'b0;
        endcase
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/alu_cz_adder.sv
module alu_cz_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]       = a_i[i] ^ b_i[i] ^ carry_d[i];
        assign carry_d[i+1]   = (a_i[i] & b_i[i]) | (carry_d[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = carry_d[WIDTH];

endmodule

// File: rtl/alu_cz_flags.sv
module alu_cz_flags #(
    parameter int WIDTH = 8
) (
    input  logic             upd_c_i,
    input  logic             upd_z_i,
    input  logic             cout_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             c_i,
    input  logic             z_i,
    output logic             c_o,
    output logic             z_o
);

    logic c_d, z_d;

    always_comb begin
        c_d = upd_c_i ? cout_i : c_i;
        z_d = upd_z_i ? ~|res_i : z_i;
    end

    assign c_o = c_d;
    assign z_o = z_d;

endmodule

// File: rtl/alu_cz.sv
module alu_cz
    import alu_cz_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    input  logic             c_i,
    input  logic             z_i,
    output logic [WIDTH-1:0] res_o,
    output logic             wr_en_o,
    output logic             c_o,
    output logic             z_o
);

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] b_add_d;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] res_d;

    alu_cz_decode u_decode (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    // Operand conditioning: B, zero or their complement
    always_comb begin
        b_add_d = ctl.zero_b ? '0 : b_i;
        if (ctl.inv_b) b_add_d = ~b_add_d;
    end

    alu_cz_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (a_i),
        .b_i    (b_add_d),
        .cin_i  (ctl.cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_comb begin
        unique case (ctl.sel)
            SEL_SUM:  res_d = sum;
            SEL_NOR:  res_d = ~(a_i | b_i);
            SEL_PASS: res_d = b_i;
            default:  res_d = a_i;
        endcase
    end

    alu_cz_flags #(.WIDTH(WIDTH)) u_flags (
        .upd_c_i (ctl.upd_c),
        .upd_z_i (ctl.upd_z),
        .cout_i  (cout),
        .res_i   (res_d),
        .c_i     (c_i),
        .z_i     (z_i),
        .c_o     (c_o),
        .z_o     (z_o)
    );

    assign res_o   = res_d;
    assign wr_en_o = ctl.wr;

    // Checks that relate decoder, adder and flag logic
    always_comb begin
        if (op_i == 3'd0)
            a_r1_add_carry: assert (c_o == (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {WIDTH{1'b1}}}));
        if (op_i == 3'd1 || op_i == 3'd2)
            a_r2_no_borrow: assert (c_o == (a_i >= b_i));
        if (op_i == 3'd2)
            a_r3_cmp_no_wb: assert (!wr_en_o);
        if (op_i >= 3'd3 && op_i <= 3'd6)
            a_r6_carry_kept: assert (c_o == c_i && wr_en_o);
        if (op_i != 3'd7)
            a_r7_zero_flag: assert (z_o == (res_o == '0));
        if (op_i == 3'd7)
            a_r8_hold: assert (c_o == c_i && z_o == z_i && !wr_en_o);
    end

endmodule

// File: tb/alu_cz_tb.sv
module alu_cz_tb;

    logic       clk = 1'b0;
    logic [7:0] a, b, res;
    logic [2:0] op;
    logic       ci, zi, wr, co, zo;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_cz u_dut (
        .a_i(a), .b_i(b), .op_i(op), .c_i(ci), .z_i(zi),
        .res_o(res), .wr_en_o(wr), .c_o(co), .z_o(zo)
    );

    // Independent reference: {res, wr, c, z}
    function automatic logic [10:0] model(input logic [7:0] x, input logic [7:0] y,
                                          input logic [2:0] f, input logic c, input logic z);
        logic [8:0] wide;
        logic [7:0] r;
        logic       w, nc, nz;
        w = 1'b1; nc = c;
        case (f)
            3'd0: begin wide = {1'b0, x} + {1'b0, y}; r = wide[7:0]; nc = wide[8]; end
            3'd1: begin r = x - y; nc = (x >= y); end
            3'd2: begin r = x - y; nc = (x >= y); w = 1'b0; end
            3'd3: r = ~(x | y);
            3'd4: r = y;
            3'd5: r = x + 8'd1;
            3'd6: r = x - 8'd1;
            default: begin r = x; w = 1'b0; end
        endcase
        nz = (f == 3'd7) ? z : (r == 8'd0);
        return {r, w, nc, nz};
    endfunction

    function automatic string tag(input logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [2:0] f,
                         input logic c, input logic z);
        logic [10:0] exp;
        @(posedge clk);
        a = x; b = y; op = f; ci = c; zi = z;
        @(negedge clk);
        exp = model(x, y, f, c, z);
        checks++;
        if ({res, wr, co, zo} !== exp) begin
            fails++;
            $display("FAIL %s (R7 zero) op=%0d a=%h b=%h c=%b z=%b: got res=%h wr=%b c=%b z=%b exp res=%h wr=%b c=%b z=%b",
                     tag(f), f, x, y, c, z, res, wr, co, zo,
                     exp[10:3], exp[2], exp[1], exp[0]);
        end
    endtask

    initial begin
        a = 8'd0; b = 8'd0; op = 3'd7; ci = 1'b0; zi = 1'b0;
        // Initial state: hold code with cleared flags
        @(negedge clk);
        checks++;
        if (wr !== 1'b0 || co !== 1'b0 || zo !== 1'b0) begin
            fails++;
            $display("FAIL R8 idle: got wr=%b c=%b z=%b exp 0 0 0", wr, co, zo);
        end
        // R1 carry boundary
        apply(8'hFF, 8'h01, 3'd0, 1'b0, 1'b0);
        apply(8'h7F, 8'h01, 3'd0, 1'b1, 1'b1);
        // R2 equal operands and borrow
        apply(8'h42, 8'h42, 3'd1, 1'b0, 1'b0);
        apply(8'h00, 8'h01, 3'd1, 1'b1, 1'b1);
        // R3 compare: flags but no write-back
        apply(8'h10, 8'h20, 3'd2, 1'b1, 1'b0);
        apply(8'h55, 8'h55, 3'd2, 1'b0, 1'b0);
        // R4 NOR
        apply(8'hF0, 8'h0F, 3'd4 - 3'd1, 1'b1, 1'b0);
        apply(8'h00, 8'h00, 3'd3, 1'b0, 1'b1);
        // R5 pass, zero and non-zero
        apply(8'hAA, 8'h00, 3'd4, 1'b1, 1'b0);
        apply(8'hAA, 8'h80, 3'd4, 1'b0, 1'b1);
        // R6 wrap with carry preserved
        apply(8'hFF, 8'h33, 3'd5, 1'b1, 1'b0);
        apply(8'h00, 8'h33, 3'd6, 1'b0, 1'b1);
        apply(8'h01, 8'h00, 3'd6, 1'b1, 1'b0);
        // R8 hold with both flag values
        apply(8'h00, 8'hFF, 3'd7, 1'b1, 1'b1);
        apply(8'h3C, 8'h00, 3'd7, 1'b0, 1'b1);
        // Random sweep covering R1..R8
        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            apply(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule